// File: doc/BRIEF.md
# Microcode Sequencer with Four-Word ROM Rows

This block steps through the microcode of a small microcoded processor. A macro-instruction opcode loaded while the sequencer is idle picks a fixed slot of sixteen consecutive micro-instructions. A 4-bit step counter then walks that slot one word per clock, so a routine shorter than sixteen words needs no jump at all. The block ends a routine when it reaches a "done" word or when the counter passes the last word of the slot, and it asks for the next opcode with a one-cycle fetch request.

The microcode store is a constant table of wide rows. Each 84-bit row holds four 21-bit micro-instructions. The opcode and the upper two counter bits address a row, and the lower two counter bits drive a 4:1 multiplexer that picks one quarter of it. The word is read combinationally, so it is valid in the same cycle as the counter value. The block decodes each word's type, raises an ALU strobe with the ALU opcode, and resolves conditional jumps against a vector of condition flags.

Top module: `useq_sequencer`

## Requirements
- R1: Synchronous active-high reset leaves the block idle: `busy` 0, `upc` 0, `fetch_req` 0, `uinst` 0.
- R2: When idle, `op_load` starts a routine: on the next cycle `busy` is 1 and `upc` = {opcode, 4'd0}. `op_load` has no effect while `busy` is 1.
- R3: If the current word is neither a taken jump nor the end of the routine, the step (`upc[3:0]`) increments by one on the next cycle and the opcode (`upc[7:4]`) is kept.
- R4: The row address is {opcode, step[3:2]} and the quarter is step[1:0]. Quarter q occupies bits [21q+20:21q] of the row, so quarter 0 is bits [20:0].
- R5: Word fields: type code = {uinst[20], uinst[19:18]}, A = uinst[17:13], B = uinst[12:0]. `utype` shows the type code. Type 0 is a conditional jump and type 1 is an ALU operation. Type 4 is "done". Types 5, 6 and 7 use the alternate A/B format and only advance. `alu_valid` is 1 exactly for a type-1 word while busy, and `alu_op` = A then and 0 otherwise.
- R6: A type-0 word is taken when `cond_i[A]` is 1. The next step is then B[7:4], and if B[12] is 1 the opcode becomes B[11:8]. Otherwise the opcode is kept.
- R7: An untaken type-0 word advances like any other word (R3).
- R8: A type-4 word raises `fetch_req` in that cycle, and the block is idle with step 0 on the next cycle.
- R9: A word at step 15 that is not a taken jump raises `fetch_req` in that cycle, and the block returns to idle with step 0.
- R10: Table contents for opcode p, step s, checked in this order: p≠0 and s=12 gives done with A=0 and B=0. Odd p and s=2 gives a type-0 jump with A={0,p} and B={p[1], p^8, 4'd10, 4'd0}. Even s gives type 1 with A={0,p^s} and B=s. Odd s gives type 7 if s=7, otherwise type 6 if s[1] is set and type 5 if it is not, with A={p,s[0]} and B=s.
- R11: While idle, `uinst` is 0 and `alu_valid` and `fetch_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_load | input | 1 | Load a macro opcode (taken only when idle) |
| op_code | input | 4 | Macro-instruction opcode |
| cond_i | input | 32 | Condition flags, indexed by the jump word's A field |
| busy | output | 1 | A routine is in progress |
| upc | output | 8 | Micro address {opcode, step} |
| uinst | output | 21 | Selected micro-instruction (0 when idle) |
| utype | output | 3 | Decoded type code |
| alu_valid | output | 1 | Current word is an ALU operation |
| alu_op | output | 5 | ALU opcode from the A field |
| fetch_req | output | 1 | Routine ends this cycle; next opcode wanted |

## Verification
Opcode 0 has no done word, so it runs all sixteen steps and separates a counter-wrap exit from a done exit. Even opcodes stop at step 12, which exposes the row and quarter selection across several rows. Odd opcodes run once with their selected flag clear and once with it set. This tells an untaken jump from a taken one, and a taken jump that keeps the opcode from one that loads a new opcode. `op_load` pulses during a run and idle cycles with no load confirm that the block ignores loads while busy and stays quiet when idle.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int OPC_W     = 4;
    localparam int STEP_W    = 4;
    localparam int WORD_W    = 21;
    localparam int QUARTERS  = 4;
    localparam int QSEL_W    = $clog2(QUARTERS);
    localparam int ROW_W     = WORD_W * QUARTERS;
    localparam int ROW_AW    = OPC_W + STEP_W - QSEL_W;
    localparam int COND_W    = 32;

    typedef enum logic [2:0] {
        UT_CJMP  = 3'd0,
        UT_ALU   = 3'd1,
        UT_DONE  = 3'd4,
        UT_MOVE  = 3'd5,
        UT_SHIFT = 3'd6,
        UT_MISC  = 3'd7
    } utype_e;

    typedef struct packed {
        logic        fmt;
        logic [1:0]  typ;
        logic [4:0]  a;
        logic [12:0] b;
    } uword_t;

    function automatic logic [2:0] type_of(uword_t w);
        return {w.fmt, w.typ};
    endfunction

    // Constant microcode content, computed rather than tabulated.
    function automatic uword_t mk_word(logic [OPC_W-1:0] p, logic [STEP_W-1:0] s);
        uword_t w;
        w = '0;
        if (p != '0 && s == 4'd12) begin
            {w.fmt, w.typ} = UT_DONE;
        end else if (p[0] && s == 4'd2) begin
            {w.fmt, w.typ} = UT_CJMP;
            w.a = {1'b0, p};
            w.b = {p[1], p ^ 4'h8, 4'd10, 4'd0};
        end else if (!s[0]) begin
            {w.fmt, w.typ} = UT_ALU;
            w.a = {1'b0, p ^ s};
            w.b = {9'd0, s};
        end else begin
            if (s == 4'd7)     {w.fmt, w.typ} = UT_MISC;
            else if (s[1])     {w.fmt, w.typ} = UT_SHIFT;
            else               {w.fmt, w.typ} = UT_MOVE;
            w.a = {p, s[0]};
            w.b = {9'd0, s};
        end
        return w;
    endfunction

    function automatic logic [ROW_W-1:0] row_image(logic [ROW_AW-1:0] r);
        logic [ROW_W-1:0] img;
        img = '0;
        for (int q = 0; q < QUARTERS; q++) begin
            img[q*WORD_W +: WORD_W] =
                mk_word(r[ROW_AW-1 -: OPC_W], {r[ROW_AW-OPC_W-1:0], QSEL_W'(q)});
        end
        return img;
    endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  logic [ROW_AW-1:0] row_addr,
    output logic [ROW_W-1:0]  row_data
);
    always_comb row_data = row_image(row_addr);
endmodule

// File: rtl/useq_qmux.sv
module useq_qmux #(
    parameter int WIDTH = 21,
    parameter int NUM   = 4,
    localparam int SEL_W = $clog2(NUM)
) (
    input  logic [WIDTH*NUM-1:0] row,
    input  logic [SEL_W-1:0]     sel,
    output logic [WIDTH-1:0]     word
);
    logic [WIDTH-1:0] lane [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_lane
        assign lane[g] = row[g*WIDTH +: WIDTH];
    end

    always_comb word = lane[sel];
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_load,
    input  logic [OPC_W-1:0]  op_code,
    input  uword_t            word,
    input  logic [COND_W-1:0] cond_i,
    output logic              busy,
    output logic [OPC_W-1:0]  opc,
    output logic [STEP_W-1:0] step,
    output logic              fetch_req
);
    typedef enum logic {S_IDLE, S_RUN} state_e;
    state_e state;

    logic [2:0] tcode;
    logic       taken;
    logic       last;

    always_comb begin
        tcode     = type_of(word);
        taken     = (state == S_RUN) && (tcode == UT_CJMP) && cond_i[word.a];
        last      = (tcode == UT_DONE) || (step == {STEP_W{1'b1}});
        fetch_req = (state == S_RUN) && !taken && last;
        busy      = (state == S_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            opc   <= '0;
            step  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (op_load) begin
                        state <= S_RUN;
                        opc   <= op_code;
                        step  <= '0;
                    end
                end
                default: begin
                    if (taken) begin
                        step <= word.b[7:4];
                        if (word.b[12]) opc <= word.b[11:8];
                    end else if (last) begin
                        state <= S_IDLE;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_load,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [COND_W-1:0] cond_i,
    output logic              busy,
    output logic [OPC_W+STEP_W-1:0] upc,
    output logic [WORD_W-1:0] uinst,
    output logic [2:0]        utype,
    output logic              alu_valid,
    output logic [4:0]        alu_op,
    output logic              fetch_req
);
    logic [OPC_W-1:0]  opc;
    logic [STEP_W-1:0] step;
    logic [ROW_AW-1:0] row_addr;
    logic [ROW_W-1:0]  row_data;
    logic [WORD_W-1:0] raw_word;
    uword_t            word;

    assign row_addr = {opc, step[STEP_W-1:QSEL_W]};

    useq_rom u_rom (
        .row_addr (row_addr),
        .row_data (row_data)
    );

    useq_qmux #(.WIDTH(WORD_W), .NUM(QUARTERS)) u_qmux (
        .row  (row_data),
        .sel  (step[QSEL_W-1:0]),
        .word (raw_word)
    );

    assign word = uword_t'(raw_word);

    useq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op_load   (op_load),
        .op_code   (op_code),
        .word      (word),
        .cond_i    (cond_i),
        .busy      (busy),
        .opc       (opc),
        .step      (step),
        .fetch_req (fetch_req)
    );

    always_comb begin
        upc       = {opc, step};
        uinst     = busy ? raw_word : '0;
        utype     = busy ? type_of(word) : 3'd0;
        alu_valid = busy && (type_of(word) == UT_ALU);
        alu_op    = alu_valid ? word.a : 5'd0;
    end
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_load,
    input logic [3:0]  op_code,
    input logic [31:0] cond_i,
    input logic        busy,
    input logic [7:0]  upc,
    input logic [20:0] uinst,
    input logic [2:0]  utype,
    input logic        alu_valid,
    input logic [4:0]  alu_op,
    input logic        fetch_req
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!busy && upc == 8'd0 && !fetch_req));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && op_load) |=> (busy && upc == {$past(op_code), 4'd0}));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (uinst == 21'd0 && !alu_valid && !fetch_req));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !op_load) |=> !busy);

    // R3
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !fetch_req && utype != 3'd0) |=>
        (busy && upc[3:0] == 4'($past(upc[3:0]) + 4'd1) && upc[7:4] == $past(upc[7:4])));

    // R6
    jump_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && utype == 3'd0 && cond_i[uinst[17:13]]) |=>
        (busy && upc[3:0] == $past(uinst[7:4])));

    // R5
    alu_flag_chk: assert property (@(posedge clk) disable iff (rst)
        alu_valid |-> (busy && utype == 3'd1));

    // R8
    done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && utype == 3'd4) |-> fetch_req);

    // R8
    end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> (!busy && upc[3:0] == 4'd0));

    // R9
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && upc[3:0] == 4'd15 && utype != 3'd0) |-> fetch_req);
endmodule

bind useq_sequencer useq_sequencer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_load   (op_load),
    .op_code   (op_code),
    .cond_i    (cond_i),
    .busy      (busy),
    .upc       (upc),
    .uinst     (uinst),
    .utype     (utype),
    .alu_valid (alu_valid),
    .alu_op    (alu_op),
    .fetch_req (fetch_req)
);

// File: tb/useq_sequencer_bench.sv
`timescale 1ns/100ps
module useq_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_load = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] cond_i = 32'd0;
    logic        busy;
    logic [7:0]  upc;
    logic [20:0] uinst;
    logic [2:0]  utype;
    logic        alu_valid;
    logic [4:0]  alu_op;
    logic        fetch_req;

    int n_checks = 0;
    int n_fail   = 0;
    int m_busy = 0, m_opc = 0, m_step = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    useq_sequencer u_useq_sequencer (
        .clk(clk), .rst(rst), .op_load(op_load), .op_code(op_code),
        .cond_i(cond_i), .busy(busy), .upc(upc), .uinst(uinst),
        .utype(utype), .alu_valid(alu_valid), .alu_op(alu_op),
        .fetch_req(fetch_req)
    );

    // Expected word per R10, packed per R5 field positions.
    function automatic logic [20:0] ref_word(int p, int s);
        int t, a, b;
        if (p != 0 && s == 12) begin t = 4; a = 0; b = 0; end
        else if ((p % 2) == 1 && s == 2) begin
            t = 0; a = p;
            b = (((p / 2) % 2) * 4096) + ((p ^ 8) * 256) + (10 * 16);
        end else if ((s % 2) == 0) begin t = 1; a = p ^ s; b = s; end
        else begin
            t = (s == 7) ? 7 : (((s / 2) % 2) == 1 ? 6 : 5);
            a = p * 2 + 1; b = s;
        end
        return 21'(t * (1 << 18) + a * (1 << 13) + b);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive inputs, compare against model, advance model.
    task automatic tick(input bit ld, input int op, input logic [31:0] cf,
                        input string focus);
        logic [20:0] w;
        int t, a, e_alu_v, e_alu_op, e_fetch, taken;
        @(negedge clk);
        op_load = ld; op_code = 4'(op); cond_i = cf;
        #1;
        w = m_busy ? ref_word(m_opc, m_step) : 21'd0;
        t = int'(w[20:18]); a = int'(w[17:13]);
        e_alu_v  = (m_busy && t == 1) ? 1 : 0;
        e_alu_op = e_alu_v ? a : 0;
        taken    = (m_busy && t == 0 && cf[a]) ? 1 : 0;
        e_fetch  = (m_busy && !taken && (t == 4 || m_step == 15)) ? 1 : 0;
        check(busy == 1'(m_busy), {"R2 ", focus}, "busy", busy, m_busy);
        check(upc == 8'(m_opc * 16 + m_step), {"R3 ", focus}, "upc", upc, m_opc*16+m_step);
        check(uinst == w, {"R4 ", focus}, "uinst", uinst, w);
        check(utype == 3'(m_busy ? t : 0), {"R5 ", focus}, "utype", utype, m_busy ? t : 0);
        check(alu_valid == 1'(e_alu_v) && alu_op == 5'(e_alu_op), {"R5 ", focus},
              "alu", {alu_valid, alu_op}, e_alu_v * 32 + e_alu_op);
        check(fetch_req == 1'(e_fetch), {"R8 ", focus}, "fetch_req", fetch_req, e_fetch);
        if (!m_busy) begin
            if (ld) begin m_busy = 1; m_opc = op; m_step = 0; end
        end else if (taken) begin
            m_step = int'(w[7:4]);
            if (w[12]) m_opc = int'(w[11:8]);
        end else if (e_fetch) begin
            m_busy = 0; m_step = 0;
        end else m_step++;
    endtask

    task automatic run_op(input int op, input logic [31:0] cf, input string focus);
        tick(1'b1, op, cf, focus);
        for (int i = 0; i < 20 && m_busy; i++) tick(1'b1, (op + 5) % 16, cf, focus);
        tick(1'b0, 0, cf, focus);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        check(!busy && upc == 8'd0 && !fetch_req && uinst == 21'd0, "R1", "reset",
              {busy, upc, fetch_req}, 0);
        // R11 idle, no load
        for (int i = 0; i < 3; i++) tick(1'b0, 0, 32'd0, "R11");
        // R9 wrap: opcode 0 has no done word; loads during run ignored (R2)
        run_op(0, 32'd0, "R9");
        // R8 done at step 12, R4/R10 over several rows
        run_op(2, 32'hFFFF_FFFF, "R10");
        run_op(6, 32'd0, "R4");
        // R7 untaken jump
        run_op(1, 32'hFFFF_FFFD, "R7");
        run_op(13, 32'h0000_0000, "R7");
        // R6 taken jump with opcode reload (bit1 of opcode set)
        run_op(3, 32'h0000_0008, "R6");
        run_op(15, 32'h0000_8000, "R6");
        // R6 taken jump keeping opcode
        run_op(5, 32'h0000_0020, "R6");
        run_op(9, 32'h0000_0200, "R6");
        // R11 idle after runs
        for (int i = 0; i < 2; i++) tick(1'b0, 7, 32'hFFFF_FFFF, "R11");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule